// File: doc/BRIEF.md
# RGB to YCbCr Pixel Converter

This block turns one pixel per cycle from 8-bit red, green and blue components into an 8-bit luma sample and two 8-bit chroma samples (blue-difference and red-difference). Each output channel is a weighted sum of the three inputs, using constant signed weights with 13 fractional bits. The sum is arithmetically shifted right by 13, an offset is added (16 for luma, 128 for each chroma channel), and the result is clamped to 0..255.

A strobe marks each valid input pixel. A matching strobe follows the result out two cycles later. The block accepts a new pixel every cycle and keeps no other state. Reset clears only the two valid flags in the pipeline; the data registers are loaded only when a valid pixel moves through them.

Top module: `rgb2ycc_conv`

## Requirements
- R1: Luma output equals 16 + ((2104·R + 4130·G + 802·B) >>> 13), clamped to 0..255.
- R2: Blue-difference output equals 128 + ((3598·B − 1217·R − 2382·G) >>> 13), clamped to 0..255.
- R3: Red-difference output equals 128 + ((3598·R − 3015·G − 583·B) >>> 13), clamped to 0..255.
- R4: The shift rounds a negative sum toward minus infinity, so pure red (255,0,0) gives blue-difference 90, not 91.
- R5: A pixel presented with in_valid high in one cycle appears with out_valid high two rising edges later, and out_valid is low for any slot whose input strobe was low.
- R6: While rst_n is low, out_valid is low, and no stale valid emerges after reset is released.
- R7: The offset is added after the shift, and every output stays within 0..255 for the extreme inputs (all-zero, all-ones, and each single primary at full scale).
- R8: Back-to-back pixels, with or without idle gaps between them, are each converted independently at a rate of one per cycle.
- R9: Outputs hold their last values while no valid pixel moves through the pipeline, regardless of the colour inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input pixel strobe |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| out_valid | output | 1 | Output pixel strobe, two cycles after in_valid |
| out_y | output | 8 | Luma |
| out_cb | output | 8 | Blue-difference chroma |
| out_cr | output | 8 | Red-difference chroma |

## Verification
The bench uses the default parameters: 8-bit components, 14-bit signed weights and a 24-bit accumulator. These sizes reach the real corner values. The pure-primary inputs drive the most negative chroma sums, where the rounding of the shift (R4) becomes visible. The all-ones input drives the largest luma sum, so headroom in the accumulator is tested. A gapped stream with one pixel per cycle shows whether the valid bit stays aligned with its data across both register stages.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_Y   = 0;
  localparam int CH_CB  = 1;
  localparam int CH_CR  = 2;

  // Signed weights, 13 fractional bits; comp 0=red, 1=green, 2=blue.
  function automatic int weight(input int ch, input int comp);
    int w;
    w = 0;
    case (ch)
      CH_Y:  case (comp) 0: w = 2104;  1: w = 4130;  default: w = 802;   endcase
      CH_CB: case (comp) 0: w = -1217; 1: w = -2382; default: w = 3598;  endcase
      default: case (comp) 0: w = 3598; 1: w = -3015; default: w = -583; endcase
    endcase
    return w;
  endfunction

  function automatic int offset(input int ch);
    return (ch == CH_Y) ? 16 : 128;
  endfunction
endpackage

// File: rtl/ycc_mac.sv
module ycc_mac #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 24,
  parameter int KR    = 0,
  parameter int KG    = 0,
  parameter int KB    = 0
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [PIX_W-1:0]        r,
  input  logic [PIX_W-1:0]        g,
  input  logic [PIX_W-1:0]        b,
  output logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] K_R = ACC_W'(KR);
  localparam logic signed [ACC_W-1:0] K_G = ACC_W'(KG);
  localparam logic signed [ACC_W-1:0] K_B = ACC_W'(KB);

  logic signed [ACC_W-1:0] r_s, g_s, b_s, acc_d;

  always_comb begin
    r_s   = ACC_W'(r);
    g_s   = ACC_W'(g);
    b_s   = ACC_W'(b);
    acc_d = K_R * r_s + K_G * g_s + K_B * b_s;
  end

  always_ff @(posedge clk) begin
    if (en) acc <= acc_d;
  end
endmodule

// File: rtl/ycc_scale.sv
module ycc_scale #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 24,
  parameter int FRAC  = 13,
  parameter int OFS   = 0
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc,
  output logic [PIX_W-1:0]        pix
);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] OFS_S   = ACC_W'(OFS);

  logic signed [ACC_W-1:0] shifted, biased;
  logic [PIX_W-1:0]        pix_d;

  always_comb begin
    shifted = acc >>> FRAC;
    biased  = shifted + OFS_S;
    if (biased < 0)            pix_d = '0;
    else if (biased > PIX_MAX) pix_d = '1;
    else                       pix_d = biased[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) pix <= pix_d;
  end
endmodule

// File: rtl/rgb2ycc_conv.sv
module rgb2ycc_conv #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 14,
  parameter int FRAC   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_cb,
  output logic [PIX_W-1:0] out_cr
);
  localparam int ACC_W = PIX_W + COEF_W + 2;

  logic                    vld_mid_q, vld_out_q;
  logic                    vld_mid_d, vld_out_d;
  logic signed [ACC_W-1:0] acc_w [ycc_pkg::NUM_CH];
  logic [PIX_W-1:0]        pix_w [ycc_pkg::NUM_CH];

  always_comb begin
    vld_mid_d = in_valid;
    vld_out_d = vld_mid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_mid_q <= 1'b0;
      vld_out_q <= 1'b0;
    end else begin
      vld_mid_q <= vld_mid_d;
      vld_out_q <= vld_out_d;
    end
  end

  for (genvar c = 0; c < ycc_pkg::NUM_CH; c++) begin : g_ch
    ycc_mac #(
      .PIX_W(PIX_W), .ACC_W(ACC_W),
      .KR(ycc_pkg::weight(c, 0)),
      .KG(ycc_pkg::weight(c, 1)),
      .KB(ycc_pkg::weight(c, 2))
    ) u_mac (
      .clk(clk), .en(in_valid), .r(in_r), .g(in_g), .b(in_b), .acc(acc_w[c])
    );
    ycc_scale #(
      .PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC(FRAC), .OFS(ycc_pkg::offset(c))
    ) u_scale (
      .clk(clk), .en(vld_mid_q), .acc(acc_w[c]), .pix(pix_w[c])
    );
  end

  assign out_valid = vld_out_q;
  assign out_y     = pix_w[ycc_pkg::CH_Y];
  assign out_cb    = pix_w[ycc_pkg::CH_CB];
  assign out_cr    = pix_w[ycc_pkg::CH_CR];
endmodule

// File: rtl/rgb2ycc_conv_chk.sv
module rgb2ycc_conv_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_y,
  input logic [PIX_W-1:0] out_cb,
  input logic [PIX_W-1:0] out_cr
);
  // R5: valid pixel emerges two edges later
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  // R5: empty slot stays empty
  a_r5_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  // R1: luma of an 8-bit pixel stays in its nominal band
  a_r1_luma_band: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_y >= 16 && out_y <= 235));
  // R2/R3: chroma stays in its nominal band
  a_r2_chroma_band: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cb >= 15 && out_cb <= 240 && out_cr >= 15 && out_cr <= 240));
  // R6: no output strobe during reset
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r6_reset_clear: assert (!out_valid);
    end
  end
endmodule

bind rgb2ycc_conv rgb2ycc_conv_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
);

// File: tb/rgb2ycc_conv_bench.sv
`timescale 1ns/1ps
module rgb2ycc_conv_bench;
  logic       clk, rst_n, in_valid, out_valid;
  logic [7:0] in_r, in_g, in_b, out_y, out_cb, out_cr;
  int checks, fails;
  bit done;

  rgb2ycc_conv u_rgb2ycc_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int clamp8(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction
  function automatic int ref_y(input int r, input int g, input int b);
    return clamp8(16 + ((2104*r + 4130*g + 802*b) >>> 13));
  endfunction
  function automatic int ref_cb(input int r, input int g, input int b);
    return clamp8(128 + ((3598*b - 1217*r - 2382*g) >>> 13));
  endfunction
  function automatic int ref_cr(input int r, input int g, input int b);
    return clamp8(128 + ((3598*r - 3015*g - 583*b) >>> 13));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pix(input string req, input int r, input int g, input int b);
    check({req, " valid"}, out_valid, 1);
    check({req, " luma R1"}, out_y, ref_y(r, g, b));
    check({req, " cb R2"}, out_cb, ref_cb(r, g, b));
    check({req, " cr R3"}, out_cr, ref_cr(r, g, b));
  endtask

  // one isolated pixel; checks the empty middle slot too
  task automatic one_pixel(input string req, input int r, input int g, input int b);
    @(negedge clk);
    in_valid = 1'b1; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    @(negedge clk);
    in_valid = 1'b0; in_r = 8'hA5; in_g = 8'h5A; in_b = 8'h3C;
    check({req, " R5 not early"}, out_valid, 0);
    @(negedge clk);
    check_pix(req, r, g, b);
    @(negedge clk);
    check({req, " R5 single strobe"}, out_valid, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b1; in_r = 8'd10; in_g = 8'd20; in_b = 8'd30;
    repeat (3) @(negedge clk);
    check("R6 valid low in reset", out_valid, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 no stale valid after reset", out_valid, 0);
  endtask

  task automatic test_main();
    one_pixel("R1 mid grey", 128, 128, 128);
    one_pixel("R2 mixed", 200, 40, 90);
    one_pixel("R3 mixed", 17, 230, 61);
  endtask

  task automatic test_extremes();
    one_pixel("R7 black", 0, 0, 0);
    one_pixel("R7 white", 255, 255, 255);
    one_pixel("R7 red", 255, 0, 0);
    check("R4 floor on negative cb", out_cb, 90);
    one_pixel("R7 green", 0, 255, 0);
    one_pixel("R7 blue", 0, 0, 255);
    check("R4 floor on negative cr", out_cr, ref_cr(0, 0, 255));
    check("R7 white luma", ref_y(255, 255, 255), 235);
  endtask

  task automatic test_stream();
    int rr[20], gg[20], bb[20];
    bit vv[20];
    for (int i = 0; i < 20; i++) begin
      rr[i] = (i * 37 + 5) % 256;
      gg[i] = (i * 91 + 200) % 256;
      bb[i] = (255 - i * 13) % 256;
      vv[i] = (i % 5 != 3);
    end
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        if (vv[i-2]) check_pix("R8 stream", rr[i-2], gg[i-2], bb[i-2]);
        else         check("R8 gap slot R5", out_valid, 0);
      end
      if (i < 20) begin
        in_valid = vv[i]; in_r = 8'(rr[i]); in_g = 8'(gg[i]); in_b = 8'(bb[i]);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic test_hold();
    one_pixel("R9 setup", 64, 192, 32);
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b0; in_r = 8'(k * 60); in_g = 8'(255 - k); in_b = 8'(k);
      @(negedge clk);
    end
    check("R9 hold luma", out_y, ref_y(64, 192, 32));
    check("R9 hold cb", out_cb, ref_cb(64, 192, 32));
    check("R9 hold cr", out_cr, ref_cr(64, 192, 32));
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    test_reset();
    test_main();
    test_extremes();
    test_stream();
    test_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule